// File: doc/BRIEF.md
# RV32I Load/Store Byte-Lane Aligner

This block sits between the execute stage of a single-cycle RV32I core and a 32-bit data memory that is addressed by whole words. Stores come in as a width code, the two lowest address bits and the source register value. The block then produces a per-byte write-enable mask and a write word in which the stored byte or halfword has been moved onto the lanes it belongs to. The memory can therefore update only those bytes and leave the rest of the word as it was.

Loads come in as the full word read back from memory, together with the width code and the low address bits of the load. The block picks out the addressed byte or halfword, moves it down to bit 0 and sign-extends or zero-extends it to 32 bits for write-back. The block is purely combinational. It never traps: halfword accesses at an odd address and word accesses at a non-zero offset are treated as unspecified. The block only reports them on two flag outputs, so that the surrounding logic or a test can exclude them.

The width code uses the standard load/store funct3 encoding. 3'b000 is a signed byte, 3'b001 a signed halfword and 3'b010 a word. For loads only, 3'b100 is an unsigned byte and 3'b101 an unsigned halfword. Every other code is unused on its path. The house preference for valid/ready streams does not apply here. Each access completes in the same cycle it is presented, as a single-cycle core requires, so every pin is a plain level signal.

Top module: `lsu_lane_align`

## Requirements
- R1: A load with funct3 3'b000 returns the byte at lane `ld_addr_lo` (bits 8*a+7 : 8*a of `ld_word`). Bits 31:8 of the result are copies of that byte's bit 7.
- R2: A load with funct3 3'b100 returns the byte at lane `ld_addr_lo` with bits 31:8 zero. A load with funct3 3'b101 returns the selected halfword with bits 31:16 zero.
- R3: A load with funct3 3'b001 takes `ld_word[31:16]` when `ld_addr_lo[1]` is 1 and `ld_word[15:0]` otherwise. Bits 31:16 of the result are copies of bit 15 of that halfword.
- R4: A load with funct3 3'b010 returns `ld_word` unchanged.
- R5: With `st_en` high and funct3 3'b000, `st_strb` is the one-hot value 1 << `st_addr_lo`. `st_data` is `st_src[7:0]` shifted left by 8 × `st_addr_lo`, with all other bits zero.
- R6: With `st_en` high and funct3 3'b001, `st_strb` is 4'b1100 when `st_addr_lo[1]` is 1 and 4'b0011 otherwise. `st_data` is `st_src[15:0]` shifted left by 16 in the first case and not shifted in the second, with all other bits zero.
- R7: With `st_en` high and funct3 3'b010, `st_strb` is 4'b1111 and `st_data` equals `st_src`.
- R8: With `st_en` low, `st_strb` is 4'b0000 whatever the other store inputs are, and `st_mis` is 0.
- R9: An unused store funct3 (3'b011 and 3'b1xx) gives zero strobes and a zero `st_data`. An unused load funct3 (3'b011, 3'b110, 3'b111) gives a zero `ld_result`.
- R10: `ld_mis` is 1 exactly when a halfword load (3'b001, 3'b101) has `ld_addr_lo[0]` set, or a word load has a non-zero `ld_addr_lo`. `st_mis` follows the same rule for enabled SH and SW stores.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| st_en | input | 1 | Store request for this cycle |
| st_funct3 | input | 3 | Store width code |
| st_addr_lo | input | 2 | Byte offset of the store within the word |
| st_src | input | 32 | Store source register value |
| st_strb | output | 4 | Per-byte write enables, bit i for bits 8i+7:8i |
| st_data | output | 32 | Lane-aligned write word |
| st_mis | output | 1 | Misaligned enabled store seen |
| ld_funct3 | input | 3 | Load width and signedness code |
| ld_addr_lo | input | 2 | Byte offset of the load within the word |
| ld_word | input | 32 | Word read from data memory |
| ld_result | output | 32 | Extended value for write-back |
| ld_mis | output | 1 | Misaligned load seen |

## Verification
The block holds no state, so a wrong internal value is a wrong lane decode or a wrong shift amount. It shows up at the ports in the same cycle the inputs are applied. A bad decode of one address offset appears as a strobe on the wrong lane, or as an extracted byte taken from a neighbouring lane. A bad sign-extension term shows only for data whose selected sign bit is 1. The sweep therefore covers every width code at every offset with data patterns that set and clear each lane's top bit.

// File: rtl/lsu_lane_pkg.sv
package lsu_lane_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_NONE = 2'd3
  } lane_size_e;

  localparam logic [2:0] F3_BYTE  = 3'b000;
  localparam logic [2:0] F3_HALF  = 3'b001;
  localparam logic [2:0] F3_WORD  = 3'b010;
  localparam logic [2:0] F3_UBYTE = 3'b100;
  localparam logic [2:0] F3_UHALF = 3'b101;

endpackage

// File: rtl/lane_width_decode.sv
module lane_width_decode
  import lsu_lane_pkg::*;
#(
  parameter bit FOR_LOAD = 1'b1
) (
  input  logic [2:0]  funct3,
  output lane_size_e  size
);

  generate
    if (FOR_LOAD) begin : g_load
      always_comb begin
        unique case (funct3)
          F3_BYTE, F3_UBYTE: size = SZ_BYTE;
          F3_HALF, F3_UHALF: size = SZ_HALF;
          F3_WORD:           size = SZ_WORD;
          default:           size = SZ_NONE;
        endcase
      end
    end else begin : g_store
      always_comb begin
        unique case (funct3)
          F3_BYTE: size = SZ_BYTE;
          F3_HALF: size = SZ_HALF;
          F3_WORD: size = SZ_WORD;
          default: size = SZ_NONE;
        endcase
      end
    end
  endgenerate

endmodule

// File: rtl/lane_store_pack.sv
module lane_store_pack
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int OFFS_W = $clog2(LANES)
) (
  input  logic              en,
  input  lane_size_e        size,
  input  logic [OFFS_W-1:0] offs,
  input  logic [DATA_W-1:0] src,
  output logic [LANES-1:0]  strb,
  output logic [DATA_W-1:0] data
);

  localparam int SH_W = OFFS_W + 3;

  logic [LANES-1:0]  lane_hit;
  logic [OFFS_W-1:0] half_base;
  logic [SH_W-1:0]   byte_sh;
  logic [SH_W-1:0]   half_sh;

  assign half_base = {offs[OFFS_W-1:1], 1'b0};
  assign byte_sh   = {offs, 3'b000};
  assign half_sh   = {half_base, 3'b000};

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    localparam logic [OFFS_W-1:0] IDX = OFFS_W'(i);
    always_comb begin
      unique case (size)
        SZ_BYTE: lane_hit[i] = (IDX == offs);
        SZ_HALF: lane_hit[i] = (IDX[OFFS_W-1:1] == offs[OFFS_W-1:1]);
        SZ_WORD: lane_hit[i] = 1'b1;
        default: lane_hit[i] = 1'b0;
      endcase
    end
  end

  assign strb = en ? lane_hit : '0;

  always_comb begin
    unique case (size)
      SZ_BYTE: data = {{(DATA_W-8){1'b0}},  src[7:0]}  << byte_sh;
      SZ_HALF: data = {{(DATA_W-16){1'b0}}, src[15:0]} << half_sh;
      SZ_WORD: data = src;
      default: data = '0;
    endcase
  end

endmodule

// File: rtl/lane_load_extract.sv
module lane_load_extract
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LANES  = DATA_W / 8,
  parameter int OFFS_W = $clog2(LANES)
) (
  input  lane_size_e        size,
  input  logic              zext,
  input  logic [OFFS_W-1:0] offs,
  input  logic [DATA_W-1:0] word,
  output logic [DATA_W-1:0] result
);

  localparam int SH_W = OFFS_W + 3;

  logic [SH_W-1:0]   byte_sh;
  logic [SH_W-1:0]   half_sh;
  logic [DATA_W-1:0] byte_down;
  logic [DATA_W-1:0] half_down;
  logic              byte_fill;
  logic              half_fill;

  assign byte_sh   = {offs, 3'b000};
  assign half_sh   = {offs[OFFS_W-1:1], 1'b0, 3'b000};
  assign byte_down = word >> byte_sh;
  assign half_down = word >> half_sh;
  assign byte_fill = ~zext & byte_down[7];
  assign half_fill = ~zext & half_down[15];

  always_comb begin
    unique case (size)
      SZ_BYTE: result = {{(DATA_W-8){byte_fill}},  byte_down[7:0]};
      SZ_HALF: result = {{(DATA_W-16){half_fill}}, half_down[15:0]};
      SZ_WORD: result = word;
      default: result = '0;
    endcase
  end

endmodule

// File: rtl/lane_misalign_detect.sv
module lane_misalign_detect
  import lsu_lane_pkg::*;
#(
  parameter int OFFS_W = 2
) (
  input  logic              active,
  input  lane_size_e        size,
  input  logic [OFFS_W-1:0] offs,
  output logic              mis
);

  logic odd_half;

  always_comb begin
    unique case (size)
      SZ_HALF: odd_half = offs[0];
      SZ_WORD: odd_half = (offs != '0);
      default: odd_half = 1'b0;
    endcase
  end

  assign mis = active & odd_half;

endmodule

// File: rtl/lsu_lane_align.sv
module lsu_lane_align
  import lsu_lane_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES  = DATA_W / 8,
  localparam int OFFS_W = $clog2(LANES)
) (
  input  logic              st_en,
  input  logic [2:0]        st_funct3,
  input  logic [OFFS_W-1:0] st_addr_lo,
  input  logic [DATA_W-1:0] st_src,
  output logic [LANES-1:0]  st_strb,
  output logic [DATA_W-1:0] st_data,
  output logic              st_mis,
  input  logic [2:0]        ld_funct3,
  input  logic [OFFS_W-1:0] ld_addr_lo,
  input  logic [DATA_W-1:0] ld_word,
  output logic [DATA_W-1:0] ld_result,
  output logic              ld_mis
);

  lane_size_e st_size;
  lane_size_e ld_size;

  lane_width_decode #(.FOR_LOAD(1'b0)) st_dec_i (
    .funct3 (st_funct3),
    .size   (st_size)
  );

  lane_width_decode #(.FOR_LOAD(1'b1)) ld_dec_i (
    .funct3 (ld_funct3),
    .size   (ld_size)
  );

  lane_store_pack #(.DATA_W(DATA_W), .LANES(LANES), .OFFS_W(OFFS_W)) st_pack_i (
    .en   (st_en),
    .size (st_size),
    .offs (st_addr_lo),
    .src  (st_src),
    .strb (st_strb),
    .data (st_data)
  );

  lane_load_extract #(.DATA_W(DATA_W), .LANES(LANES), .OFFS_W(OFFS_W)) ld_ext_i (
    .size   (ld_size),
    .zext   (ld_funct3[2]),
    .offs   (ld_addr_lo),
    .word   (ld_word),
    .result (ld_result)
  );

  lane_misalign_detect #(.OFFS_W(OFFS_W)) st_mis_i (
    .active (st_en),
    .size   (st_size),
    .offs   (st_addr_lo),
    .mis    (st_mis)
  );

  lane_misalign_detect #(.OFFS_W(OFFS_W)) ld_mis_i (
    .active (1'b1),
    .size   (ld_size),
    .offs   (ld_addr_lo),
    .mis    (ld_mis)
  );

endmodule

// File: rtl/lsu_lane_align_chk.sv
module lsu_lane_align_chk (
  input logic        st_en,
  input logic [2:0]  st_funct3,
  input logic [1:0]  st_addr_lo,
  input logic [31:0] st_src,
  input logic [3:0]  st_strb,
  input logic [31:0] st_data,
  input logic        st_mis,
  input logic [2:0]  ld_funct3,
  input logic [1:0]  ld_addr_lo,
  input logic [31:0] ld_word,
  input logic [31:0] ld_result,
  input logic        ld_mis
);

  always_comb begin
    // R8
    strb_idle_chk: assert (st_en || (st_strb == 4'b0000 && !st_mis));
    // R7
    word_pass_chk: assert (!(st_en && st_funct3 == 3'b010) ||
                           (st_strb == 4'b1111 && st_data == st_src));
    // R5
    byte_onehot_chk: assert (!(st_en && st_funct3 == 3'b000) ||
                             ($countones(st_strb) == 1 && st_strb[st_addr_lo]));
    // R6
    half_pair_chk: assert (!(st_en && st_funct3 == 3'b001) ||
                           (st_strb == 4'b0011 || st_strb == 4'b1100));
    // R1
    lb_sign_chk: assert (ld_funct3 != 3'b000 ||
                         ld_result[31:8] == {24{ld_result[7]}});
    // R4
    lw_pass_chk: assert (ld_funct3 != 3'b010 || ld_result == ld_word);
    // R9
    ld_unused_chk: assert (!(ld_funct3 == 3'b011 || ld_funct3[2:1] == 2'b11) ||
                           ld_result == 32'h0);
    // R10
    ld_mis_chk: assert (!ld_mis || ld_funct3 == 3'b001 || ld_funct3 == 3'b101 ||
                        ld_funct3 == 3'b010);
  end

endmodule

bind lsu_lane_align lsu_lane_align_chk chk_i (
  .st_en      (st_en),
  .st_funct3  (st_funct3),
  .st_addr_lo (st_addr_lo),
  .st_src     (st_src),
  .st_strb    (st_strb),
  .st_data    (st_data),
  .st_mis     (st_mis),
  .ld_funct3  (ld_funct3),
  .ld_addr_lo (ld_addr_lo),
  .ld_word    (ld_word),
  .ld_result  (ld_result),
  .ld_mis     (ld_mis)
);

// File: tb/lsu_lane_align_tb_top.sv
`timescale 1ns/1ps
module lsu_lane_align_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        st_en = 1'b0;
  logic [2:0]  st_funct3 = 3'b000;
  logic [1:0]  st_addr_lo = 2'b00;
  logic [31:0] st_src = 32'h0;
  logic [3:0]  st_strb;
  logic [31:0] st_data;
  logic        st_mis;
  logic [2:0]  ld_funct3 = 3'b000;
  logic [1:0]  ld_addr_lo = 2'b00;
  logic [31:0] ld_word = 32'h0;
  logic [31:0] ld_result;
  logic        ld_mis;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  lsu_lane_align dut_i (
    .st_en(st_en), .st_funct3(st_funct3), .st_addr_lo(st_addr_lo),
    .st_src(st_src), .st_strb(st_strb), .st_data(st_data), .st_mis(st_mis),
    .ld_funct3(ld_funct3), .ld_addr_lo(ld_addr_lo), .ld_word(ld_word),
    .ld_result(ld_result), .ld_mis(ld_mis)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %08h expected %08h (st f3=%0d a=%0d en=%0b, ld f3=%0d a=%0d)",
               req, act, exp, st_funct3, st_addr_lo, st_en, ld_funct3, ld_addr_lo);
    end
  endtask

  function automatic logic [31:0] pattern(input int k);
    case (k)
      0: return 32'h0000_0000;
      1: return 32'hFFFF_FFFF;
      2: return 32'h8080_8080;
      3: return 32'h7F7F_7F7F;
      4: return 32'h1234_5678;
      5: return 32'hDEAD_BEEF;
      6: return 32'h00FF_00FF;
      7: return 32'h8000_7FFF;
      default: return (32'(k) * 32'h9E37_79B9) ^ 32'h5A5A_0F0F;
    endcase
  endfunction

  function automatic string ld_req(input int f3);
    case (f3)
      0: return "R1";
      1: return "R3";
      2: return "R4";
      4, 5: return "R2";
      default: return "R9";
    endcase
  endfunction

  function automatic string st_req(input int f3, input bit en);
    if (!en) return "R8";
    case (f3)
      0: return "R5";
      1: return "R6";
      2: return "R7";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [31:0] exp_load(input int f3, input int a, input logic [31:0] w);
    logic [31:0] b, h;
    b = (w / (32'd1 << (8 * a))) % 32'd256;
    h = (w / (32'd1 << (16 * (a / 2)))) % 32'd65536;
    case (f3)
      0: return (b >= 32'd128) ? b + 32'hFFFF_FF00 : b;
      1: return (h >= 32'd32768) ? h + 32'hFFFF_0000 : h;
      2: return w;
      4: return b;
      5: return h;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_strb(input int f3, input int a, input bit en);
    if (!en) return 32'h0;
    case (f3)
      0: return 32'd1 << a;
      1: return (a >= 2) ? 32'd12 : 32'd3;
      2: return 32'd15;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_sdata(input int f3, input int a, input logic [31:0] s);
    case (f3)
      0: return (s % 32'd256) * (32'd1 << (8 * a));
      1: return (s % 32'd65536) * ((a >= 2) ? 32'd65536 : 32'd1);
      2: return s;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] exp_mis(input int f3, input int a, input bit is_ld);
    bit half, word;
    half = (f3 == 1) || (is_ld && f3 == 5);
    word = (f3 == 2);
    return (half && (a % 2 == 1)) || (word && a != 0) ? 32'd1 : 32'd0;
  endfunction

  // Watchdog: a hung run is counted as a failure and still prints the summary.
  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below 20000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // Idle state after reset: no store request.
    check("R8 idle strobes", {28'h0, st_strb}, 32'h0);
    check("R8 idle misalign", {31'h0, st_mis}, 32'h0);
    check("R1 idle load", ld_result, 32'h0);

    for (int p = 0; p < 16; p++) begin
      for (int f3 = 0; f3 < 8; f3++) begin
        for (int a = 0; a < 4; a++) begin
          for (int en = 0; en < 2; en++) begin
            logic [31:0] w, s;
            w = pattern(p);
            s = {w[15:0], w[31:16]} ^ 32'hA5C3_3C5A;
            @(posedge clk);
            #1;
            st_en = en[0]; st_funct3 = 3'(f3); st_addr_lo = 2'(a); st_src = s;
            ld_funct3 = 3'(f3); ld_addr_lo = 2'(a); ld_word = w;
            @(negedge clk);
            check(st_req(f3, en[0]), {28'h0, st_strb}, exp_strb(f3, a, en[0]));
            if (en[0]) check(st_req(f3, 1'b1), st_data, exp_sdata(f3, a, s));
            check(ld_req(f3), ld_result, exp_load(f3, a, w));
            check("R10 load", {31'h0, ld_mis}, exp_mis(f3, a, 1'b1));
            check(en[0] ? "R10 store" : "R8 misalign",
                  {31'h0, st_mis}, en[0] ? exp_mis(f3, a, 1'b0) : 32'h0);
          end
        end
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule